// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Controller

This block watches the hot-plug detect line of a display transmitter and reports connect and disconnect events as interrupts. The raw input passes through a two-stage synchronizer. A programmable glitch filter follows it and changes its output level only after the new level has held for a set number of prescaled samples. A rising edge of the filtered level latches a connect event and a falling edge latches a separate disconnect event. The interrupt line of the neighbouring core controller is also shown as a status bit. One masked and registered interrupt output combines all of these sources.

Software uses a small register port. Writes take effect on the clock edge where the write enable is high. Reads are registered and return the register selected by the address of the previous cycle. A filter register sets the prescaler and the stability count. Other registers give the raw status, a write-one-to-clear register, an active-high enable mask and a live view of the filtered level. The filtered level is also available on a port.

Top module: `hpd_irq_ctrl`

## Requirements
- R1: A rising edge of the filtered level sets status bit 1 (connect) on the following clock edge. The bit stays set until it is cleared.
- R2: A falling edge of the filtered level sets status bit 2 (disconnect) on the following clock edge. The bit stays set until it is cleared.
- R3: Status bit 0 shows the level of `core_irq_in` one cycle late. Writes to the clear register do not change it.
- R4: Writing to address 2 clears each of status bits 1 and 2 whose write-data bit is 1. A status bit whose write-data bit is 0 keeps its value.
- R5: The mask register at address 3 uses bits 2:0, and 1 enables a source. `irq_o` is a level signal. It is the OR over the status bits ANDed with their mask bits, registered once. The mask resets to 0.
- R6: When an edge event and a clear of the same bit fall on the same clock edge, the bit is set after that edge.
- R7: The filter samples the synchronized input once every P+1 cycles. The filtered level takes the sampled value after N consecutive samples that differ from the current level. N equal to 0 acts as 1. A sample that equals the level restarts the count.
- R8: The filter register at address 0 holds P in bits 15:12 and N in bits 11:0. Its reset value is 0xA0A0.
- R9: Address 4 bit 0 and `hpd_level_o` both show the filtered level. The level resets to 0 (no sink).
- R10: `cfg_rdata` returns the register selected by the previous cycle's `cfg_addr`. Address 1 returns status bits 2:0. Address 2 and unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpd_in | input | 1 | Asynchronous hot-plug detect line |
| core_irq_in | input | 1 | Interrupt line of the core controller |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined masked interrupt, level-sensitive |
| hpd_level_o | output | 1 | Filtered hot-plug level |

## Verification
The assertions check these rules on every cycle:
- Each filtered edge sets its status bit.
- Status bits stay set unless a one is written to clear them, and an event beats a clear on the same edge.
- An all-zero mask keeps the interrupt low.
- The filtered level moves only on a prescaler tick, and only to the value just sampled.

Only the bench's scenarios can show the following:
- Short pulses are rejected.
- The default filter setting gives the expected delay.
- Zero bits in a clear write leave their status bits alone.
- The core interrupt bit cannot be cleared.

A behavioural model in the bench also tracks the exact cycle of every read and interrupt change.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;
  typedef logic [2:0] reg_addr_t;

  localparam reg_addr_t ADR_FILT = 3'd0;
  localparam reg_addr_t ADR_STAT = 3'd1;
  localparam reg_addr_t ADR_CLR  = 3'd2;
  localparam reg_addr_t ADR_MASK = 3'd3;
  localparam reg_addr_t ADR_LVL  = 3'd4;

  localparam int SRC_N    = 3;
  localparam int BIT_CORE = 0;
  localparam int BIT_RISE = 1;
  localparam int BIT_FALL = 2;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hpd_glitch_filter.sv
module hpd_glitch_filter #(
  parameter int PRESC_W = 4,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [CNT_W-1:0]   need_i,
  output logic               level_o
);
  logic [PRESC_W-1:0] pc_q;
  logic [CNT_W-1:0]   run_q;
  logic               lvl_q;
  logic               tick;
  logic [CNT_W:0]     need_eff;
  logic [CNT_W:0]     run_inc;

  assign tick     = (pc_q >= presc_i);
  assign need_eff = (need_i == '0) ? (CNT_W+1)'(1) : {1'b0, need_i};
  assign run_inc  = {1'b0, run_q} + (CNT_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      run_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      pc_q <= tick ? '0 : pc_q + 1'b1;
      if (tick) begin
        if (smp_i != lvl_q) begin
          if (run_inc >= need_eff) begin
            lvl_q <= smp_i;
            run_q <= '0;
          end else begin
            run_q <= run_inc[CNT_W-1:0];
          end
        end else begin
          run_q <= '0;
        end
      end
    end
  end

  assign level_o = lvl_q;

  // R7: the level holds between prescaler ticks
  p_hold_off_tick_r7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(lvl_q));
  // R7: a level change always adopts the value that was sampled
  p_follow_sample_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl_q) |-> (lvl_q == $past(smp_i)));
endmodule

// File: rtl/hpd_event_regs.sv
module hpd_event_regs
  import hpd_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             level_i,
  input  logic             core_i,
  input  logic             clr_we_i,
  input  logic [SRC_N-1:0] clr_bits_i,
  input  logic [SRC_N-1:0] mask_i,
  output logic [SRC_N-1:0] sts_o,
  output logic             irq_o
);
  logic             lvl_d;
  logic             core_q;
  logic             irq_q;
  logic [SRC_N-1:0] evt;
  logic [SRC_N-1:0] sts;

  assign evt[BIT_CORE] = 1'b0;
  assign evt[BIT_RISE] = level_i & ~lvl_d;
  assign evt[BIT_FALL] = ~level_i & lvl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d  <= 1'b0;
      core_q <= 1'b0;
    end else begin
      lvl_d  <= level_i;
      core_q <= core_i;
    end
  end

  assign sts[BIT_CORE] = core_q;

  for (genvar k = BIT_RISE; k < SRC_N; k++) begin : g_sticky
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst) bit_q <= 1'b0;
      else     bit_q <= evt[k] | (bit_q & ~(clr_we_i & clr_bits_i[k]));
    end
    assign sts[k] = bit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(sts & mask_i);
  end

  assign sts_o = sts;
  assign irq_o = irq_q;

  p_rise_sets_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(level_i) |=> sts[BIT_RISE]);
  p_fall_sets_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(level_i) |=> sts[BIT_FALL]);
  p_core_mirror_r3: assert property (@(posedge clk) disable iff (rst)
    core_i |=> sts[BIT_CORE]);
  p_zero_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (sts[BIT_RISE] && !(clr_we_i && clr_bits_i[BIT_RISE])) |=> sts[BIT_RISE]);
  p_one_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_we_i && clr_bits_i[BIT_FALL] && !$fell(level_i)) |=> !sts[BIT_FALL]);
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '0) |=> !irq_q);
  p_event_wins_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(level_i) && clr_we_i && clr_bits_i[BIT_RISE]) |=> sts[BIT_RISE]);
endmodule

// File: rtl/hpd_irq_ctrl.sv
module hpd_irq_ctrl
  import hpd_irq_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter int              PRESC_W     = 4,
  parameter int              CNT_W       = 12,
  parameter int              SYNC_STAGES = 2,
  parameter logic [15:0]     FILT_RST    = 16'hA0A0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hpd_in,
  input  logic              core_irq_in,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              irq_o,
  output logic              hpd_level_o
);
  localparam int FILT_W = PRESC_W + CNT_W;

  logic [FILT_W-1:0] filt_q;
  logic [SRC_N-1:0]  mask_q;
  logic [DATA_W-1:0] rdata_q;
  logic              smp;
  logic              level;
  logic [SRC_N-1:0]  sts;
  logic              clr_we;

  assign clr_we = cfg_we && (cfg_addr == ADR_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= FILT_RST[FILT_W-1:0];
      mask_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == ADR_FILT) filt_q <= cfg_wdata[FILT_W-1:0];
      if (cfg_addr == ADR_MASK) mask_q <= cfg_wdata[SRC_N-1:0];
    end
  end

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (hpd_in),
    .q   (smp)
  );

  hpd_glitch_filter #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .smp_i   (smp),
    .presc_i (filt_q[FILT_W-1:CNT_W]),
    .need_i  (filt_q[CNT_W-1:0]),
    .level_o (level)
  );

  hpd_event_regs u_evt (
    .clk        (clk),
    .rst        (rst),
    .level_i    (level),
    .core_i     (core_irq_in),
    .clr_we_i   (clr_we),
    .clr_bits_i (cfg_wdata[SRC_N-1:0]),
    .mask_i     (mask_q),
    .sts_o      (sts),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (cfg_addr)
        ADR_FILT: rdata_q <= DATA_W'(filt_q);
        ADR_STAT: rdata_q <= DATA_W'(sts);
        ADR_MASK: rdata_q <= DATA_W'(mask_q);
        ADR_LVL:  rdata_q <= DATA_W'(level);
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign cfg_rdata   = rdata_q;
  assign hpd_level_o = level;

  p_mask_write_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == ADR_MASK) |=> (mask_q == $past(cfg_wdata[SRC_N-1:0])));
  p_clr_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr == ADR_CLR) |=> (cfg_rdata == '0));
endmodule

// File: tb/tb_hpd_irq_ctrl.sv
module tb_hpd_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hpd_in = 1'b0;
  logic        core_irq_in = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq_o;
  logic        hpd_level_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit model_ok = 0;

  always #5 clk = ~clk;

  hpd_irq_ctrl dut (
    .clk(clk), .rst(rst), .hpd_in(hpd_in), .core_irq_in(core_irq_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_o(irq_o), .hpd_level_o(hpd_level_o)
  );

  // behavioural reference model
  int sync_q[$];
  int m_pc, m_cnt, m_lvl, m_lvld, m_core, m_rise, m_fall, m_mask, m_filt, m_irq;
  int m_rd;
  int t_sts, t_clr, t_presc, t_need, t_evr, t_evf, t_smp;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      sync_q = '{0, 0};
      m_pc = 0; m_cnt = 0; m_lvl = 0; m_lvld = 0; m_core = 0;
      m_rise = 0; m_fall = 0; m_mask = 0; m_filt = 'hA0A0; m_irq = 0; m_rd = 0;
      model_ok = 1;
    end else begin
      t_sts   = m_core + 2 * m_rise + 4 * m_fall;
      t_clr   = (cfg_we && cfg_addr == 3'd2) ? int'(cfg_wdata[2:0]) : 0;
      t_presc = (m_filt / 4096) % 16;
      t_need  = m_filt % 4096;
      if (t_need == 0) t_need = 1;
      t_evr = (m_lvl == 1 && m_lvld == 0) ? 1 : 0;
      t_evf = (m_lvl == 0 && m_lvld == 1) ? 1 : 0;
      t_smp = sync_q[0];
      case (cfg_addr)
        3'd0: m_rd = m_filt;
        3'd1: m_rd = t_sts;
        3'd3: m_rd = m_mask;
        3'd4: m_rd = m_lvl;
        default: m_rd = 0;
      endcase
      m_irq = ((t_sts & m_mask) != 0) ? 1 : 0;
      m_rise = (t_evr == 1 || (m_rise == 1 && (t_clr & 2) == 0)) ? 1 : 0;
      m_fall = (t_evf == 1 || (m_fall == 1 && (t_clr & 4) == 0)) ? 1 : 0;
      m_lvld = m_lvl;
      if (m_pc >= t_presc) begin
        m_pc = 0;
        if (t_smp != m_lvl) begin
          if (m_cnt + 1 >= t_need) begin m_lvl = t_smp; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end else m_cnt = 0;
      end else m_pc = m_pc + 1;
      void'(sync_q.pop_front());
      sync_q.push_back(int'(hpd_in));
      m_core = int'(core_irq_in);
      if (cfg_we && cfg_addr == 3'd3) m_mask = int'(cfg_wdata[2:0]);
      if (cfg_we && cfg_addr == 3'd0) m_filt = int'(cfg_wdata[15:0]);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_ok && !rst) begin
      check("R5 model irq_o", 32'(irq_o), 32'(m_irq));
      check("R9 model level", 32'(hpd_level_o), 32'(m_lvl));
      check("R10 model rdata", cfg_rdata, 32'(m_rd));
    end
  end

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); v = cfg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    bit seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(3'd0, v); check("R8 filter reset value", v, 32'hA0A0);
    rd(3'd1, v); check("R1 status after reset", v, 32'h0);
    rd(3'd4, v); check("R9 level after reset", v, 32'h0);
    check("R5 irq after reset", 32'(irq_o), 32'h0);

    // short filter: P=0, N=3; a two-cycle glitch must be rejected
    wr(3'd0, 32'h0000_0003);
    rd(3'd0, v); check("R8 filter readback", v, 32'h3);
    seen = 0;
    @(negedge clk); hpd_in = 1'b1;
    @(negedge clk); @(negedge clk); hpd_in = 1'b0;
    repeat (10) begin @(negedge clk); if (hpd_level_o) seen = 1; end
    check("R7 glitch rejected", 32'(seen), 32'h0);

    // steady connect
    hpd_in = 1'b1; idle(10);
    check("R9 level port high", 32'(hpd_level_o), 32'h1);
    rd(3'd4, v); check("R9 level register", v, 32'h1);
    rd(3'd1, v); check("R1 connect latched", v, 32'h2);
    idle(3);
    check("R5 masked off irq low", 32'(irq_o), 32'h0);
    wr(3'd3, 32'h2); idle(2);
    check("R5 enabled irq high", 32'(irq_o), 32'h1);

    // clear with zero in rise position keeps it
    wr(3'd2, 32'h4); rd(3'd1, v); check("R4 zero bit keeps status", v, 32'h2);
    wr(3'd2, 32'h2); rd(3'd1, v); check("R4 one bit clears status", v, 32'h0);
    idle(2); check("R5 irq drops after clear", 32'(irq_o), 32'h0);

    // disconnect
    hpd_in = 1'b0; idle(10);
    rd(3'd1, v); check("R2 disconnect latched", v, 32'h4);
    wr(3'd3, 32'h4); idle(2);
    check("R5 fall source irq", 32'(irq_o), 32'h1);

    // core interrupt pass-through
    wr(3'd2, 32'h7); wr(3'd3, 32'h0);
    core_irq_in = 1'b1; idle(2);
    rd(3'd1, v); check("R3 core bit mirrors input", v, 32'h1);
    wr(3'd2, 32'h1); rd(3'd1, v); check("R3 core bit not clearable", v, 32'h1);
    wr(3'd3, 32'h1); idle(2);
    check("R3 core irq routed", 32'(irq_o), 32'h1);
    core_irq_in = 1'b0; idle(3);
    check("R3 core irq follows low", 32'(irq_o), 32'h0);
    rd(3'd1, v); check("R3 core bit low", v, 32'h0);

    // event and clear on the same edge
    wr(3'd0, 32'h0000_0002);
    hpd_in = 1'b1;
    seen = 0;
    while (!seen) begin @(negedge clk); if (hpd_level_o) seen = 1; end
    cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 32'h2;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    rd(3'd1, v); check("R6 event beats clear", v & 32'h2, 32'h2);

    // N=0 behaves as 1, with a prescaler of 2
    wr(3'd0, 32'h0000_2000);
    hpd_in = 1'b0; idle(12);
    check("R7 N zero acts as one", 32'(hpd_level_o), 32'h0);

    // unused and write-only addresses read as zero
    rd(3'd2, v); check("R10 clear reads zero", v, 32'h0);
    rd(3'd7, v); check("R10 unused reads zero", v, 32'h0);

    // default filter: P=10, N=160 -> about 1760 cycles
    wr(3'd0, 32'h0000_A0A0);
    hpd_in = 1'b1; idle(1500);
    check("R7 default filter still low", 32'(hpd_level_o), 32'h0);
    idle(800);
    check("R7 default filter settles", 32'(hpd_level_o), 32'h1);

    idle(5);
    finish_up();
  end
endmodule